// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Sequencer

This block steers the program counter of a 16-bit DSP through hardware loops without spending any cycles on loop bookkeeping. It watches the instruction stream and recognises four loop-start opcodes: a single-instruction repeat and a block repeat, and each of them can take its count from a register-file read or from an 8-bit immediate. When a loop starts with a nonzero count, the block stores one frame on its internal stacks. The frame holds the body start address, the inclusive last address of the body and the remaining pass count.

On every fetch the block compares the address just fetched with the newest frame's last address. On a match it counts down the pass counter and then either branches back to the body start or pops the frame and falls through. The chosen next fetch address is driven combinationally in the same cycle, so a loop-back costs no bubble. Up to four loops can be nested. An attempt to open a fifth frame is refused, and a sticky error flag records it.

The fetch side is a plain qualified stream: `fetch_valid` marks a cycle that carries a fetched word. The sequencer never stalls, so there is no ready signal and no back-pressure. When `fetch_valid` is low the block holds its state and passes the sequential address through. All inputs that describe a fetch (`fetch_pc`, `fetch_word`, `seq_pc`, and `rf_data` for the register selected by `rf_sel`) belong to the same cycle.

Top module: `loop_sequencer`

## Requirements
- R1: The opcodes are recognised exactly as follows. `0x0040|r` is a single repeat counted by a register. `0x1000|n` is a single repeat with immediate count n. `0x0060|r` is a block repeat counted by a register. `0x1100|n` is a block repeat with immediate count n. Here r is the 5-bit field in bits 4:0 and n is the 8-bit field in bits 7:0. For the register forms, `rf_sel` equals bits 4:0 of the fetched word in the same cycle.
- R2: A single repeat with nonzero count N, fetched at address A, makes the instruction at `seq_pc` (A+1) execute N times in a row. Execution then continues at A+2.
- R3: A block repeat uses two words: the opcode word, then a word that holds the inclusive end address E. With nonzero count N, the body runs from the word after the address word through E, N times over.
- R4: A zero count opens no frame. A single repeat then continues at `seq_pc`+1, which skips one following word. A block repeat continues at E+1. `loop_depth` does not change.
- R5: When `fetch_valid` is high, at least one frame is open, and `fetch_pc` equals the newest frame's end address, the pass count is reduced by one. If the result is nonzero, `next_pc` is the newest frame's body start. If it is zero, the frame is removed and `next_pc` is `seq_pc`.
- R6: Up to four frames nest, and `loop_depth` reports how many frames are open (0 to 4).
- R7: A loop start with a nonzero count while four frames are open leaves the frames unchanged and gives `next_pc` = `seq_pc`. It also sets `loop_err`, which stays set until reset.
- R8: While the synchronous active-high `rst` is high, the next clock edge closes all frames, clears `loop_err` and drops any half-decoded block repeat.
- R9: While `fetch_valid` is low, `next_pc` equals `seq_pc`, and `loop_depth` and `loop_err` hold, whatever the other inputs carry.
- R10: An end-address match takes precedence over opcode decode: the word fetched at a matching address is not treated as a loop start. The address word of a block repeat is not compared against any end address.
- R11: For every accepted fetch that is neither a loop start nor an end match, `next_pc` equals `seq_pc` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | This cycle carries a fetched word |
| fetch_pc | input | ADDR_W | Address of the word being fetched |
| fetch_word | input | 16 | Fetched instruction word |
| seq_pc | input | ADDR_W | Sequential successor of `fetch_pc` |
| rf_sel | output | REG_SEL_W | Register index for a register-counted loop |
| rf_data | input | ADDR_W | Read data of the register named by `rf_sel` |
| next_pc | output | ADDR_W | Address to fetch next |
| loop_depth | output | $clog2(DEPTH+1) | Number of open loop frames |
| loop_err | output | 1 | Sticky nesting-overflow flag |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and counts, a 5-bit register index, an 8-bit immediate and four frames. The depth of four means a fifth nested block repeat fits in a ten-word program, so the overflow path and the sticky flag come up in a directed case. The bench keeps counts between 0 and 3, so zero-count skips, single passes and repeated passes all appear within short random programs, and each random program nests a block repeat and a single repeat inside an outer block repeat.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;

  localparam int WORD_W = 16;

  // frame lanes, one stack per lane
  localparam int LN_RET = 0;
  localparam int LN_END = 1;
  localparam int LN_CNT = 2;
  localparam int N_LANES = 3;

  // opcode patterns (upper bits of the first word)
  localparam logic [10:0] OPH_REP_REG = 11'b000_0000_0010;
  localparam logic [10:0] OPH_BLK_REG = 11'b000_0000_0011;
  localparam logic [7:0]  OPH_REP_IMM = 8'h10;
  localparam logic [7:0]  OPH_BLK_IMM = 8'h11;

  typedef enum logic [2:0] {
    LK_NONE,
    LK_REP_REG,
    LK_REP_IMM,
    LK_BLK_REG,
    LK_BLK_IMM
  } loop_kind_e;

  function automatic logic kind_is_single(loop_kind_e k);
    return (k == LK_REP_REG) || (k == LK_REP_IMM);
  endfunction

  function automatic logic kind_is_block(loop_kind_e k);
    return (k == LK_BLK_REG) || (k == LK_BLK_IMM);
  endfunction

  function automatic logic kind_uses_reg(loop_kind_e k);
    return (k == LK_REP_REG) || (k == LK_BLK_REG);
  endfunction

endpackage

// File: rtl/loop_decoder.sv
module loop_decoder
  import loop_seq_pkg::*;
#(
  parameter int REG_SEL_W = 5,
  parameter int IMM_W     = 8
) (
  input  logic [WORD_W-1:0]    word,
  output loop_kind_e           kind,
  output logic [REG_SEL_W-1:0] reg_sel,
  output logic [IMM_W-1:0]     imm
);

  logic hit_rep_reg, hit_blk_reg, hit_rep_imm, hit_blk_imm;

  assign hit_rep_reg = (word[WORD_W-1:5] == OPH_REP_REG);
  assign hit_blk_reg = (word[WORD_W-1:5] == OPH_BLK_REG);
  assign hit_rep_imm = (word[WORD_W-1:8] == OPH_REP_IMM);
  assign hit_blk_imm = (word[WORD_W-1:8] == OPH_BLK_IMM);

  always_comb begin
    kind = LK_NONE;
    if (hit_rep_reg)      kind = LK_REP_REG;
    else if (hit_blk_reg) kind = LK_BLK_REG;
    else if (hit_rep_imm) kind = LK_REP_IMM;
    else if (hit_blk_imm) kind = LK_BLK_IMM;
  end

  assign reg_sel = word[REG_SEL_W-1:0];
  assign imm     = word[IMM_W-1:0];

endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] push_idx,
  output logic [AW-1:0] top_idx
);

  localparam logic [DW-1:0] FULL_LVL = DW'(DEPTH);

  logic [DW-1:0] lvl_m1;

  assign full     = (level == FULL_LVL);
  assign empty    = (level == '0);
  assign lvl_m1   = level - 1'b1;
  assign push_idx = level[AW-1:0];
  assign top_idx  = lvl_m1[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (push && !full) begin
      level <= level + 1'b1;
    end else if (pop && !empty) begin
      level <= lvl_m1;
    end
  end

endmodule

// File: rtl/stack_lane.sv
module stack_lane #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (wr_en) begin
      slot[wr_idx] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
  import loop_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DEPTH     = 4,
  parameter int REG_SEL_W = 5,
  parameter int IMM_W     = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int DW       = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_pc,
  input  logic [WORD_W-1:0]    fetch_word,
  input  logic [ADDR_W-1:0]    seq_pc,
  output logic [REG_SEL_W-1:0] rf_sel,
  input  logic [ADDR_W-1:0]    rf_data,
  output logic [ADDR_W-1:0]    next_pc,
  output logic [DW-1:0]        loop_depth,
  output logic                 loop_err
);

  // ---------------- decode ----------------
  loop_kind_e        kind;
  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] start_cnt;

  loop_decoder #(.REG_SEL_W(REG_SEL_W), .IMM_W(IMM_W)) u_dec (
    .word    (fetch_word),
    .kind    (kind),
    .reg_sel (rf_sel),
    .imm     (imm)
  );

  assign start_cnt = kind_uses_reg(kind) ? rf_data : ADDR_W'(imm);

  // ---------------- frame pointer ----------------
  logic          do_push, do_pop, do_upd;
  logic          st_full, st_empty;
  logic [AW-1:0] push_idx, top_idx;

  stack_ptr #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .push     (do_push),
    .pop      (do_pop),
    .level    (loop_depth),
    .full     (st_full),
    .empty    (st_empty),
    .push_idx (push_idx),
    .top_idx  (top_idx)
  );

  // ---------------- three lanes ----------------
  logic [N_LANES-1:0][ADDR_W-1:0] lane_push;
  logic [N_LANES-1:0][ADDR_W-1:0] lane_top;
  logic [ADDR_W-1:0] push_ret, push_end, push_cnt, cnt_dec;

  assign lane_push[LN_RET] = push_ret;
  assign lane_push[LN_END] = push_end;
  assign lane_push[LN_CNT] = push_cnt;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic              wr;
    logic [AW-1:0]     widx;
    logic [ADDR_W-1:0] wdat;
    if (k == LN_CNT) begin : g_count
      assign wr   = do_push | do_upd;
      assign widx = do_push ? push_idx : top_idx;
      assign wdat = do_push ? lane_push[k] : cnt_dec;
    end else begin : g_addr
      assign wr   = do_push;
      assign widx = push_idx;
      assign wdat = lane_push[k];
    end
    stack_lane #(.W(ADDR_W), .DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr),
      .wr_idx  (widx),
      .wr_data (wdat),
      .rd_idx  (top_idx),
      .rd_data (lane_top[k])
    );
  end

  assign cnt_dec = lane_top[LN_CNT] - 1'b1;

  // ---------------- block-repeat second word tracking ----------------
  logic              blk_wait;
  logic [ADDR_W-1:0] blk_cnt;
  logic              arm_blk, err_set, end_hit;

  assign end_hit = fetch_valid && !blk_wait && !st_empty &&
                   (fetch_pc == lane_top[LN_END]);

  // ---------------- next-address selection ----------------
  always_comb begin
    do_push  = 1'b0;
    do_pop   = 1'b0;
    do_upd   = 1'b0;
    arm_blk  = 1'b0;
    err_set  = 1'b0;
    push_ret = seq_pc;
    push_end = seq_pc;
    push_cnt = start_cnt;
    next_pc  = seq_pc;
    if (fetch_valid && blk_wait) begin
      // address word of a block repeat
      push_end = ADDR_W'(fetch_word);
      push_cnt = blk_cnt;
      if (blk_cnt == '0)   next_pc = push_end + 1'b1;
      else if (st_full)    err_set = 1'b1;
      else                 do_push = 1'b1;
    end else if (end_hit) begin
      if (cnt_dec != '0) begin
        do_upd  = 1'b1;
        next_pc = lane_top[LN_RET];
      end else begin
        do_pop  = 1'b1;
      end
    end else if (fetch_valid) begin
      if (kind_is_single(kind)) begin
        if (start_cnt == '0) next_pc = seq_pc + 1'b1;
        else if (st_full)    err_set = 1'b1;
        else                 do_push = 1'b1;
      end else if (kind_is_block(kind)) begin
        arm_blk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_wait <= 1'b0;
      blk_cnt  <= '0;
      loop_err <= 1'b0;
    end else begin
      if (fetch_valid) blk_wait <= arm_blk;
      if (arm_blk)     blk_cnt  <= start_cnt;
      if (err_set)     loop_err <= 1'b1;
    end
  end

endmodule

// File: rtl/loop_seq_checker.sv
module loop_seq_checker #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int DW     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] seq_pc,
  input logic [ADDR_W-1:0] next_pc,
  input logic [DW-1:0]     loop_depth,
  input logic              loop_err,
  input logic              blk_wait
);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (loop_depth == '0 && !loop_err && !blk_wait));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    loop_err |=> loop_err);

  p_depth_bound_r6: assert property (@(posedge clk) disable iff (rst)
    loop_depth <= DW'(DEPTH));

  p_depth_step_r6: assert property (@(posedge clk) disable iff (rst)
    (loop_depth == $past(loop_depth)) ||
    (loop_depth == $past(loop_depth) + 1'b1) ||
    (loop_depth == $past(loop_depth) - 1'b1));

  p_idle_pass_r9: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> next_pc == seq_pc);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> ($stable(loop_depth) && $stable(loop_err)));

endmodule

bind loop_sequencer loop_seq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .seq_pc      (seq_pc),
  .next_pc     (next_pc),
  .loop_depth  (loop_depth),
  .loop_err    (loop_err),
  .blk_wait    (blk_wait)
);

// File: tb/test_loop_sequencer.sv
module test_loop_sequencer;
  localparam int DW = 3;
  localparam logic [15:0] FILL = 16'h4A00;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid;
  logic [15:0] fetch_pc, fetch_word, seq_pc, rf_data, next_pc;
  logic [4:0]  rf_sel;
  logic [DW-1:0] loop_depth;
  logic        loop_err;

  logic [15:0] prog [64];
  logic [15:0] regs [32];

  always #10 clk = ~clk;
  assign rf_data = regs[rf_sel];

  loop_sequencer i_loop_sequencer (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_word(fetch_word), .seq_pc(seq_pc), .rf_sel(rf_sel), .rf_data(rf_data),
    .next_pc(next_pc), .loop_depth(loop_depth), .loop_err(loop_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int max_depth;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model of the requirements
  logic [15:0] m_ret [4], m_end [4], m_cnt [4];
  int  m_d;
  bit  m_err, m_wait;
  logic [15:0] m_pend;

  task automatic model_reset();
    m_d = 0; m_err = 0; m_wait = 0; m_pend = 0;
  endtask

  task automatic model_push(input logic [15:0] r, input logic [15:0] e, input logic [15:0] c,
                            output string tag);
    if (m_d == 4) begin m_err = 1; tag = "R7"; end
    else begin m_ret[m_d] = r; m_end[m_d] = e; m_cnt[m_d] = c; m_d++; end
  endtask

  task automatic model_step(input logic [15:0] pc, input logic [15:0] w, input logic [15:0] sq,
                            output logic [15:0] nxt, output string tag);
    logic [15:0] c;
    nxt = sq; tag = "R11";
    if (m_wait) begin
      m_wait = 0; tag = "R3";
      if (m_pend == 0) begin nxt = w + 16'd1; tag = "R4"; end
      else model_push(sq, w, m_pend, tag);
    end else if (m_d > 0 && pc == m_end[m_d-1]) begin
      tag = "R5";
      if (m_cnt[m_d-1] - 16'd1 != 0) begin
        m_cnt[m_d-1] = m_cnt[m_d-1] - 16'd1; nxt = m_ret[m_d-1];
      end else m_d--;
    end else if (w[15:5] == 11'h002 || w[15:8] == 8'h10) begin
      c = (w[15:5] == 11'h002) ? regs[w[4:0]] : {8'h00, w[7:0]};
      tag = "R2";
      if (c == 0) begin nxt = sq + 16'd1; tag = "R4"; end
      else model_push(sq, sq, c, tag);
    end else if (w[15:5] == 11'h003 || w[15:8] == 8'h11) begin
      m_pend = (w[15:5] == 11'h003) ? regs[w[4:0]] : {8'h00, w[7:0]};
      m_wait = 1; tag = "R3";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; fetch_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    chk("R8 depth", loop_depth, 0);
    chk("R8 err", loop_err, 0);
  endtask

  task automatic run_prog(input logic [15:0] halt, input bit idles);
    logic [15:0] pc, nxt;
    string tag;
    int steps;
    pc = 0; steps = 0;
    while (pc != halt && steps < 3000) begin
      steps++;
      @(negedge clk);
      if (idles && ($urandom % 8) == 0) begin
        fetch_valid = 0;
        fetch_pc = 16'($urandom); fetch_word = 16'h1100 | 16'($urandom % 4);
        seq_pc = 16'($urandom);
        #5;
        chk("R9 next_pc", next_pc, seq_pc);
        @(posedge clk); #1;
        chk("R9 depth", loop_depth, m_d);
      end else begin
        fetch_valid = 1;
        fetch_pc = pc; fetch_word = prog[pc[5:0]]; seq_pc = pc + 16'd1;
        #5;
        if (!m_wait && (fetch_word[15:5] == 11'h002 || fetch_word[15:5] == 11'h003))
          chk("R1 rf_sel", rf_sel, fetch_word[4:0]);
        model_step(pc, fetch_word, seq_pc, nxt, tag);
        chk(tag, next_pc, nxt);
        @(posedge clk); #1;
        chk("R6 depth", loop_depth, m_d);
        if (int'(loop_depth) > max_depth) max_depth = int'(loop_depth);
        pc = nxt;
      end
    end
    chk("R11 reached end", pc, halt);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = FILL | 16'(i);
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int p, e0, e1, f;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) regs[i] = 16'(i % 4);
    rst = 1; fetch_valid = 0; fetch_pc = 0; fetch_word = 0; seq_pc = 0;
    do_reset();

    // single repeat, immediate 3 (R2)
    clear_prog(); prog[0] = 16'h1003; run_prog(16'd4, 0);
    // single repeat zero count skips one word (R4)
    do_reset(); clear_prog(); prog[0] = 16'h1000; run_prog(16'd4, 0);
    // register-counted block with zero register (R4), then reg 3 = 3 passes (R3)
    do_reset(); clear_prog(); prog[0] = 16'h0060; prog[1] = 16'd3; run_prog(16'd5, 0);
    do_reset(); clear_prog(); prog[0] = 16'h0063; prog[1] = 16'd4; run_prog(16'd6, 0);
    // end match over a loop opcode at the end address (R10)
    do_reset(); clear_prog();
    prog[0] = 16'h1102; prog[1] = 16'd3; prog[3] = 16'h1005; run_prog(16'd5, 0);
    // five nested frames: overflow (R7) and depth four (R6)
    do_reset(); clear_prog(); max_depth = 0;
    for (int k = 0; k < 5; k++) begin
      prog[2*k]   = (k == 0) ? 16'h1102 : 16'h1101;
      prog[2*k+1] = 16'(20 - k);
    end
    run_prog(16'd21, 0);
    chk("R7 err set", loop_err, 1);
    chk("R6 peak depth", max_depth, 4);
    do_reset();

    // random nested programs
    for (int t = 0; t < 40; t++) begin
      clear_prog();
      for (int i = 0; i < 32; i++) regs[i] = 16'($urandom % 4);
      prog[0] = 16'h1100 | 16'($urandom % 4);
      p = 2 + int'($urandom % 3);
      prog[p] = 16'h0060 | 16'($urandom % 32);
      f = 1 + int'($urandom % 3);
      e1 = p + 1 + f;
      prog[p+1] = 16'(e1);
      p = e1 + 1;
      prog[p] = 16'h1000 | 16'($urandom % 4);
      e0 = p + 2 + int'($urandom % 3);
      prog[1] = 16'(e0);
      run_prog(16'(e0 + 1), 1);
      chk("R6 final depth", loop_depth, 0);
      if (t % 10 == 9) do_reset();
    end
    finish_run();
  end
endmodule